// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit connects a 64-bit integer load/store datapath to a memory port that is one doubleword wide. A load hands it the raw doubleword read from memory, together with the low three bits of the byte address, the access size, an unsigned-load control and the current byte-order mode. It picks out the addressed bytes and assembles them into a right-justified value. Signed loads are sign-extended to 64 bits and unsigned loads are zero-extended. A store hands it the register value. The unit places the low-order bytes of that value on the lanes the access addresses and raises one write enable for each of those lanes.

The load and store paths are purely combinational. A loaded value is ready in the same cycle the memory word arrives. The unit holds no data and never stalls, so it has no ready signal and applies no back-pressure. An access is qualified by `acc_valid` alone, and the source may present a new access every cycle. Every access must be naturally aligned. A misaligned access produces zero load data and no write enables. It also raises a one-cycle fault flag on the following clock, which the pipeline's exception logic consumes.

The byte-order bit can change from one access to the next. In little-endian mode, byte offset k of the doubleword is carried on lane k. In big-endian mode, it is carried on lane 7-k.

Top module: `lsa_align_unit`

## Requirements
- R1: `acc_size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword, so N = 1, 2, 4 or 8 bytes. For an aligned little-endian load, result byte i (i < N, byte 0 least significant) is taken from `mem_rdata` lane `addr_lo + i`, where lane j is bits 8j+7:8j.
- R2: For an aligned big-endian load, the most-significant byte of the datum sits at the lowest address. Result byte i is taken from lane `8 - addr_lo - N + i`.
- R3: When `acc_unsigned` is 0, every result bit above the loaded N bytes equals the top bit of the loaded datum.
- R4: When `acc_unsigned` is 1, every result bit above the loaded N bytes is zero.
- R5: For an aligned little-endian store, `st_be` bit j is 1 exactly for lanes `addr_lo` to `addr_lo + N - 1`. Lane `addr_lo + i` of `st_wdata` carries byte i of `st_data`, and all other lanes are zero. The enable count equals N.
- R6: For an aligned big-endian store, the enabled lanes are `8 - addr_lo - N` to `7 - addr_lo`. Lane `8 - addr_lo - N + i` carries byte i of `st_data`, and all other lanes are zero.
- R7: An access is misaligned when `addr_lo` is not a multiple of N. A valid misaligned access drives `ld_data`, `st_be` and `st_wdata` to zero in both byte orders.
- R8: `misalign_o` is low out of reset. It is high in the cycle after each clock edge that samples a valid misaligned access, and low after any other edge. Back-to-back misaligned accesses keep it high.
- R9: With `acc_valid` low, all data outputs and enables are zero and no fault is raised. A load drives no enables, and a store returns zero load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | Access size code |
| acc_unsigned | input | 1 | Zero-extend instead of sign-extend loads |
| big_endian | input | 1 | Byte-order mode, 1 = big-endian |
| addr_lo | input | 3 | Byte offset within the doubleword |
| mem_rdata | input | 64 | Raw doubleword read from memory |
| st_data | input | 64 | Register value to store |
| ld_data | output | 64 | Aligned, extended load result |
| st_wdata | output | 64 | Store data placed on its lanes |
| st_be | output | 8 | Per-lane write enables |
| misalign_o | output | 1 | Registered one-cycle misalignment fault |

## Verification
Lane steering and the alignment fault can act on the same access. A misaligned access must both suppress the steering in the current cycle and raise the flag on the next edge. The bench provokes this with misaligned loads and stores in both byte orders, interleaved in the vector table between aligned accesses. For each access it judges the combinational outputs just after the inputs settle, and the flag just after the following edge. It also runs two misaligned accesses back to back, and then a misaligned address with `acc_valid` low, to confirm that the flag tracks each access and not a stale state.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsa_lane_map.sv
// Lane base, datum byte mask and alignment check for one access.
module lsa_lane_map #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] addr,
  input  lsa_pkg::acc_size_e size,
  input  logic             big_endian,
  output logic [OFF_W-1:0] base,
  output logic [LANES-1:0] dmask,
  output logic             misaligned
);
  logic [OFF_W-1:0] nm1;  // access bytes minus one

  always_comb begin
    nm1        = ~({OFF_W{1'b1}} << size);
    misaligned = |(addr & nm1);
    // Big-endian: LANES - addr - N == (~addr) - (N - 1) modulo LANES
    base       = big_endian ? (~addr - nm1) : addr;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign dmask[i] = (OFF_W'(i) <= nm1);
  end
endmodule

// File: rtl/lsa_load_path.sv
// Extracts the addressed bytes and extends them to full width.
module lsa_load_path #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = 8 * LANES
) (
  input  logic [DW-1:0]    mem_rdata,
  input  logic [OFF_W-1:0] base,
  input  logic [LANES-1:0] dmask,
  input  logic             zero_ext,
  input  logic             en,
  output logic [DW-1:0]    ld_data
);
  logic [DW-1:0]    shifted;
  logic [LANES-1:0] top_hit;
  logic             ext_bit;

  assign shifted = mem_rdata >> {base, 3'b000};

  // One-hot pick of the datum's most significant byte's sign bit.
  for (genvar i = 0; i < LANES; i++) begin : g_top
    if (i == LANES - 1) begin : g_last
      assign top_hit[i] = dmask[i] & shifted[8*i+7];
    end else begin : g_mid
      assign top_hit[i] = dmask[i] & ~dmask[i+1] & shifted[8*i+7];
    end
  end

  assign ext_bit = ~zero_ext & (|top_hit);

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign ld_data[8*i +: 8] = !en      ? 8'h00 :
                               dmask[i] ? shifted[8*i +: 8] : {8{ext_bit}};
  end
endmodule

// File: rtl/lsa_store_path.sv
// Places the low-order register bytes on their lanes and builds enables.
module lsa_store_path #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = 8 * LANES
) (
  input  logic [DW-1:0]    st_data,
  input  logic [OFF_W-1:0] base,
  input  logic [LANES-1:0] dmask,
  input  logic             en,
  output logic [DW-1:0]    st_wdata,
  output logic [LANES-1:0] st_be
);
  logic [DW-1:0] trimmed;

  for (genvar i = 0; i < LANES; i++) begin : g_trim
    assign trimmed[8*i +: 8] = dmask[i] ? st_data[8*i +: 8] : 8'h00;
  end

  assign st_wdata = en ? (trimmed << {base, 3'b000}) : '0;
  assign st_be    = en ? (dmask << base) : '0;
endmodule

// File: rtl/lsa_align_unit.sv
module lsa_align_unit #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_store,
  input  logic [1:0]       acc_size,
  input  logic             acc_unsigned,
  input  logic             big_endian,
  input  logic [OFF_W-1:0] addr_lo,
  input  logic [DW-1:0]    mem_rdata,
  input  logic [DW-1:0]    st_data,
  output logic [DW-1:0]    ld_data,
  output logic [DW-1:0]    st_wdata,
  output logic [LANES-1:0] st_be,
  output logic             misalign_o
);
  logic [OFF_W-1:0] base;
  logic [LANES-1:0] dmask;
  logic             misaligned;
  logic             ld_en, st_en;

  lsa_lane_map #(.LANES(LANES)) u_map (
    .addr       (addr_lo),
    .size       (lsa_pkg::acc_size_e'(acc_size)),
    .big_endian (big_endian),
    .base       (base),
    .dmask      (dmask),
    .misaligned (misaligned)
  );

  assign ld_en = acc_valid & ~acc_store & ~misaligned;
  assign st_en = acc_valid &  acc_store & ~misaligned;

  lsa_load_path #(.LANES(LANES)) u_load (
    .mem_rdata (mem_rdata),
    .base      (base),
    .dmask     (dmask),
    .zero_ext  (acc_unsigned),
    .en        (ld_en),
    .ld_data   (ld_data)
  );

  lsa_store_path #(.LANES(LANES)) u_store (
    .st_data  (st_data),
    .base     (base),
    .dmask    (dmask),
    .en       (st_en),
    .st_wdata (st_wdata),
    .st_be    (st_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) misalign_o <= 1'b0;
    else        misalign_o <= acc_valid & misaligned;
  end
endmodule

// File: rtl/lsa_align_chk.sv
module lsa_align_chk #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = 8 * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_store,
  input logic [1:0]       acc_size,
  input logic [OFF_W-1:0] addr_lo,
  input logic [DW-1:0]    ld_data,
  input logic [LANES-1:0] st_be,
  input logic             misalign_o
);
  logic [OFF_W-1:0] size_low;
  logic             bad;

  always_comb begin
    size_low = OFF_W'((32'd1 << acc_size) - 32'd1);
    bad      = (addr_lo & size_low) != '0;
  end

  // R7: misaligned access is suppressed
  p_mis_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && bad) |-> (st_be == '0 && ld_data == '0));

  // R8: fault flag follows a misaligned access by one edge
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && bad) |=> misalign_o);

  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && bad) |=> !misalign_o);

  // R5: aligned store enables exactly N lanes
  p_be_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_store && !bad) |-> ($countones(st_be) == (32'd1 << acc_size)));

  // R9: idle cycles and loads drive no enables
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (st_be == '0 && ld_data == '0));

  p_load_no_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_store) |-> st_be == '0);
endmodule

bind lsa_align_unit lsa_align_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_store  (acc_store),
  .acc_size   (acc_size),
  .addr_lo    (addr_lo),
  .ld_data    (ld_data),
  .st_be      (st_be),
  .misalign_o (misalign_o)
);

// File: tb/lsa_align_unit_test.sv
module lsa_align_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_store = 1'b0, acc_unsigned = 1'b0, big_endian = 1'b0;
  logic [1:0]  acc_size = 2'd0;
  logic [2:0]  addr_lo = 3'd0;
  logic [63:0] mem_rdata = 64'h7F80_1234_9ABC_0156;
  logic [63:0] st_data   = 64'h0102_0304_A5B6_C7D8;
  logic [63:0] ld_data, st_wdata;
  logic [7:0]  st_be;
  logic        misalign_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  lsa_align_unit uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_size(acc_size), .acc_unsigned(acc_unsigned), .big_endian(big_endian),
    .addr_lo(addr_lo), .mem_rdata(mem_rdata), .st_data(st_data),
    .ld_data(ld_data), .st_wdata(st_wdata), .st_be(st_be), .misalign_o(misalign_o)
  );

  // {store, size, unsigned, big_endian, addr, mis, exp_ld, exp_be, exp_wd}
  localparam int NV = 25;
  localparam logic [144:0] TBL [NV] = '{
    {1'b0,2'd0,1'b0,1'b0,3'd2,1'b0,64'hFFFFFFFFFFFFFFBC,8'h00,64'h0},        // R1 R3
    {1'b0,2'd0,1'b1,1'b0,3'd2,1'b0,64'h00000000000000BC,8'h00,64'h0},        // R4
    {1'b0,2'd1,1'b0,1'b0,3'd6,1'b0,64'h0000000000007F80,8'h00,64'h0},        // R1
    {1'b0,2'd2,1'b0,1'b0,3'd0,1'b0,64'hFFFFFFFF9ABC0156,8'h00,64'h0},        // R3
    {1'b0,2'd3,1'b0,1'b0,3'd0,1'b0,64'h7F8012349ABC0156,8'h00,64'h0},        // R1
    {1'b0,2'd0,1'b0,1'b1,3'd2,1'b0,64'h0000000000000012,8'h00,64'h0},        // R2
    {1'b0,2'd1,1'b0,1'b1,3'd2,1'b0,64'h0000000000001234,8'h00,64'h0},        // R2
    {1'b0,2'd2,1'b1,1'b1,3'd4,1'b0,64'h000000009ABC0156,8'h00,64'h0},        // R4
    {1'b0,2'd3,1'b0,1'b1,3'd0,1'b0,64'h7F8012349ABC0156,8'h00,64'h0},        // R2
    {1'b0,2'd1,1'b0,1'b1,3'd0,1'b0,64'h0000000000007F80,8'h00,64'h0},        // R2
    {1'b0,2'd0,1'b0,1'b1,3'd1,1'b0,64'hFFFFFFFFFFFFFF80,8'h00,64'h0},        // R2 R3
    {1'b0,2'd1,1'b0,1'b0,3'd3,1'b1,64'h0,8'h00,64'h0},                       // R7
    {1'b0,2'd2,1'b0,1'b1,3'd2,1'b1,64'h0,8'h00,64'h0},                       // R7
    {1'b0,2'd3,1'b0,1'b0,3'd4,1'b1,64'h0,8'h00,64'h0},                       // R7
    {1'b1,2'd0,1'b0,1'b0,3'd5,1'b0,64'h0,8'h20,64'h0000D80000000000},        // R5
    {1'b1,2'd1,1'b0,1'b0,3'd2,1'b0,64'h0,8'h0C,64'h00000000C7D80000},        // R5
    {1'b1,2'd2,1'b0,1'b0,3'd4,1'b0,64'h0,8'hF0,64'hA5B6C7D800000000},        // R5
    {1'b1,2'd3,1'b0,1'b0,3'd0,1'b0,64'h0,8'hFF,64'h01020304A5B6C7D8},        // R5
    {1'b1,2'd0,1'b0,1'b1,3'd5,1'b0,64'h0,8'h04,64'h0000000000D80000},        // R6
    {1'b1,2'd1,1'b0,1'b1,3'd6,1'b0,64'h0,8'h03,64'h000000000000C7D8},        // R6
    {1'b1,2'd2,1'b0,1'b1,3'd0,1'b0,64'h0,8'hF0,64'hA5B6C7D800000000},        // R6
    {1'b1,2'd3,1'b0,1'b1,3'd0,1'b0,64'h0,8'hFF,64'h01020304A5B6C7D8},        // R6
    {1'b1,2'd1,1'b0,1'b0,3'd1,1'b1,64'h0,8'h00,64'h0},                       // R7
    {1'b1,2'd3,1'b0,1'b1,3'd4,1'b1,64'h0,8'h00,64'h0},                       // R7
    {1'b1,2'd2,1'b0,1'b0,3'd6,1'b1,64'h0,8'h00,64'h0}                        // R7
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset flag", {63'd0, misalign_o}, 64'd0);
    chk("R9 reset ld_data", ld_data, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [144:0] e;
      string tag;
      e = TBL[v];
      @(negedge clk);
      acc_valid    = 1'b1;
      acc_store    = e[144];
      acc_size     = e[143:142];
      acc_unsigned = e[141];
      big_endian   = e[140];
      addr_lo      = e[139:137];
      #1;
      if (e[136])      tag = "R7";
      else if (e[144]) tag = e[140] ? "R6" : "R5";
      else if (e[141]) tag = "R4";
      else             tag = e[140] ? "R2" : "R1";
      chk($sformatf("%s vec %0d ld_data", tag, v), ld_data, e[135:72]);
      chk($sformatf("%s vec %0d st_be", tag, v), {56'd0, st_be}, {56'd0, e[71:64]});
      chk($sformatf("%s vec %0d st_wdata", tag, v), st_wdata, e[63:0]);
      @(posedge clk);
      #1;
      chk($sformatf("R8 vec %0d misalign_o", v), {63'd0, misalign_o}, {63'd0, e[136]});
    end

    // R8: back-to-back misaligned accesses keep the flag high
    @(negedge clk);
    acc_valid = 1'b1; acc_store = 1'b0; acc_size = 2'd2; big_endian = 1'b0; addr_lo = 3'd1;
    @(posedge clk); #1;
    chk("R8 first of pair", {63'd0, misalign_o}, 64'd1);
    @(negedge clk);
    acc_store = 1'b1; acc_size = 2'd1; big_endian = 1'b1; addr_lo = 3'd7;
    @(posedge clk); #1;
    chk("R8 second of pair", {63'd0, misalign_o}, 64'd1);

    // R9: misaligned address with no valid raises nothing, outputs quiet
    @(negedge clk);
    acc_valid = 1'b0; acc_store = 1'b1; acc_size = 2'd3; addr_lo = 3'd3;
    #1;
    chk("R9 idle st_be", {56'd0, st_be}, 64'd0);
    chk("R9 idle st_wdata", st_wdata, 64'd0);
    chk("R9 idle ld_data", ld_data, 64'd0);
    @(posedge clk); #1;
    chk("R9 idle no fault", {63'd0, misalign_o}, 64'd0);

    // R9: a store returns no load data; R3 with a positive byte
    @(negedge clk);
    acc_valid = 1'b1; acc_store = 1'b1; acc_size = 2'd0; addr_lo = 3'd0; big_endian = 1'b0;
    #1;
    chk("R9 store ld_data", ld_data, 64'd0);
    acc_store = 1'b0; acc_unsigned = 1'b0; addr_lo = 3'd7;
    #1;
    chk("R3 positive byte", ld_data, 64'h000000000000007F);

    @(negedge clk);
    acc_valid = 1'b0;
    @(posedge clk); #1;
    finish_run();
  end
endmodule